// File: doc/BRIEF.md
# Inverter and PFC Gate Interlock with Fault Supervision

This block sits between the PWM generator and the gate drivers of a three-phase inverter bridge plus one boost PFC switch. For each phase it takes an upper and a lower switch command, along with one PFC command. It turns them into seven registered gate enables and keeps the two switches of a leg from conducting together. Every input is asynchronous and passes through a two-flop synchronizer. Each command then passes a minimum-pulse filter, so edges that do not hold for a set number of cycles never reach a gate.

Protection arrives as digital flags from the analog front end. These are two over-current comparators (bridge and PFC), one main-supply undervoltage flag and one bootstrap-supply undervoltage flag per phase. Over-current must persist through a blanking window before it counts as a trip. A trip switches every gate off and pulls the active-low fault line down. The block then recovers by itself once the over-current condition has gone and a clearance delay has run out. Main-supply undervoltage also forces every gate off with fault asserted, but it releases as soon as the flag drops. A bootstrap undervoltage quietly removes only the upper switch of its own phase.

The control pins are plain levels with no handshake, because each gate and flag is a continuous state and not a transfer. The blanking, clearance and filter widths are parameters counted in clock cycles. Their defaults suit a 100 MHz clock: 35 cycles (350 ns), 185000 cycles (1.85 ms) and 100 cycles (1 µs).

Top module: `gate_interlock`

## Requirements
- R1: While reset is asserted and afterwards, all seven gates stay off and fault_n stays low until the synchronized uv_main reads 0. The uv_main synchronizer resets to the undervoltage state.
- R2: For phase i (bit i of the 3-bit buses), hi_cmd[i]=1 with lo_cmd[i]=0 drives gate_hi[i]=1 and gate_lo[i]=0. The opposite commands give the opposite gates. Both commands at 0 give both gates at 0. pfc_cmd drives gate_pfc.
- R3: When hi_cmd[i] and lo_cmd[i] are both 1, gate_hi[i] and gate_lo[i] are both 0, and the other phases are unaffected.
- R4: When oc_inv or oc_pfc stays high for BLANK_CYC consecutive synchronized cycles, a trip occurs: all seven gates go to 0 and fault_n goes to 0. A shorter high pulse changes no output.
- R5: After a trip, outputs come back only once both over-current flags are low and CLEAR_CYC further cycles have passed. fault_n stays 0 throughout that wait.
- R6: Any over-current flag seen during the clearance wait restarts the wait, and the block stays shut down.
- R7: uv_main=1 forces all seven gates to 0 and fault_n to 0. Normal outputs return within 3 cycles of uv_main falling, with no clearance wait.
- R8: uv_boot[i]=1 forces gate_hi[i] to 0 and leaves gate_lo[i], the other phases, gate_pfc and fault_n unchanged.
- R9: A command level, whether high or low, that holds for fewer than MIN_PULSE_CYC synchronized cycles never reaches a gate. A level that holds for MIN_PULSE_CYC cycles does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | 3 | Upper switch command per phase |
| lo_cmd | input | 3 | Lower switch command per phase |
| pfc_cmd | input | 1 | PFC switch command |
| oc_inv | input | 1 | Bridge over-current comparator flag |
| oc_pfc | input | 1 | PFC over-current comparator flag |
| uv_main | input | 1 | Main supply undervoltage flag |
| uv_boot | input | 3 | Bootstrap supply undervoltage flag per phase |
| gate_hi | output | 3 | Upper gate enable per phase |
| gate_lo | output | 3 | Lower gate enable per phase |
| gate_pfc | output | 1 | PFC gate enable |
| fault_n | output | 1 | Active-low fault, low while a global fault is active |

## Verification
The embedded properties watch several things on every cycle: that no leg whose filtered commands are both high turns either gate on, that a blanked trip or main undervoltage is followed by all gates off with fault low, and that a bootstrap undervoltage always removes its upper gate. They also check that the filters and the recovery state machine change state only when their counters reach their limits. The exact duration of the clearance wait, the restart of that wait on a glitch, the rejection of short command and over-current pulses, and the release without delay from main undervoltage all depend on timed sequences of input changes. Only the bench scenarios can show those.

// File: rtl/gi_pkg.sv
`timescale 1ns/1ps
package gi_pkg;
  localparam int unsigned PHASES = 3;
  localparam int unsigned NCMD   = 2 * PHASES + 1;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TRIP  = 2'd1,
    ST_CLEAR = 2'd2
  } rec_state_t;
endpackage

// File: rtl/gi_sync2.sv
`timescale 1ns/1ps
module gi_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/gi_pulse_filter.sv
`timescale 1ns/1ps
module gi_pulse_filter #(
  parameter int unsigned MIN_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(MIN_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      dout <= 1'b0;
    end else if (din == dout) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      dout <= din;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R9
  filt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> ($past(cnt) == LAST && $past(din) == dout));
endmodule

// File: rtl/gi_oc_blank.sv
`timescale 1ns/1ps
module gi_oc_blank #(
  parameter int unsigned BLANK_CYC = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  output logic hit
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!oc_in)        cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign hit = oc_in && (cnt == LIMIT);

  // R4
  blank_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hit) |-> $past(oc_in));
endmodule

// File: rtl/gi_trip_recovery.sv
`timescale 1ns/1ps
module gi_trip_recovery
  import gi_pkg::*;
#(
  parameter int unsigned CLEAR_CYC = 185000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_in,
  input  logic hit,
  output logic shut
);
  localparam int unsigned CW = $clog2(CLEAR_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_CYC - 1);

  rec_state_t    state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (hit) state <= ST_TRIP;
        end
        ST_TRIP: begin
          if (!oc_in) begin
            state <= ST_CLEAR;
            cnt   <= '0;
          end
        end
        ST_CLEAR: begin
          if (hit)              state <= ST_TRIP;
          else if (oc_in)       cnt   <= '0;
          else if (cnt == LAST) state <= ST_RUN;
          else                  cnt   <= cnt + 1'b1;
        end
        default: state <= ST_TRIP;
      endcase
    end
  end

  assign shut = (state != ST_RUN);

  // R5
  clear_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) == ST_CLEAR) |-> ($past(cnt) == LAST && !$past(oc_in)));

  // R6
  retrip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN && oc_in) |=> (state != ST_RUN));
endmodule

// File: rtl/gate_interlock.sv
`timescale 1ns/1ps
module gate_interlock
  import gi_pkg::*;
#(
  parameter int unsigned BLANK_CYC     = 35,
  parameter int unsigned CLEAR_CYC     = 185000,
  parameter int unsigned MIN_PULSE_CYC = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hi_cmd,
  input  logic [2:0] lo_cmd,
  input  logic       pfc_cmd,
  input  logic       oc_inv,
  input  logic       oc_pfc,
  input  logic       uv_main,
  input  logic [2:0] uv_boot,
  output logic [2:0] gate_hi,
  output logic [2:0] gate_lo,
  output logic       gate_pfc,
  output logic       fault_n
);
  logic [NCMD-1:0]   cmd_s;
  logic [NCMD-1:0]   cmd_f;
  logic [1:0]        oc_s;
  logic              uv_main_s;
  logic [PHASES-1:0] uv_boot_s;
  logic              oc_any;
  logic              oc_hit;
  logic              oc_shut;
  logic              shut_all;
  logic [PHASES-1:0] hi_f;
  logic [PHASES-1:0] lo_f;

  gi_sync2 #(.W(NCMD), .RST_VAL('0)) u_sync_cmd (
    .clk(clk), .rst_n(rst_n), .d({pfc_cmd, lo_cmd, hi_cmd}), .q(cmd_s));

  gi_sync2 #(.W(2), .RST_VAL(2'b00)) u_sync_oc (
    .clk(clk), .rst_n(rst_n), .d({oc_pfc, oc_inv}), .q(oc_s));

  gi_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync_uvm (
    .clk(clk), .rst_n(rst_n), .d(uv_main), .q(uv_main_s));

  gi_sync2 #(.W(PHASES), .RST_VAL('0)) u_sync_uvb (
    .clk(clk), .rst_n(rst_n), .d(uv_boot), .q(uv_boot_s));

  for (genvar c = 0; c < NCMD; c++) begin : g_filt
    gi_pulse_filter #(.MIN_CYC(MIN_PULSE_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(cmd_s[c]), .dout(cmd_f[c]));
  end

  assign hi_f   = cmd_f[PHASES-1:0];
  assign lo_f   = cmd_f[2*PHASES-1:PHASES];
  assign oc_any = |oc_s;

  gi_oc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_any), .hit(oc_hit));

  gi_trip_recovery #(.CLEAR_CYC(CLEAR_CYC)) u_recov (
    .clk(clk), .rst_n(rst_n), .oc_in(oc_any), .hit(oc_hit), .shut(oc_shut));

  assign shut_all = oc_hit | oc_shut | uv_main_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi  <= '0;
      gate_lo  <= '0;
      gate_pfc <= 1'b0;
      fault_n  <= 1'b0;
    end else begin
      gate_hi  <= shut_all ? '0 : (hi_f & ~lo_f & ~uv_boot_s);
      gate_lo  <= shut_all ? '0 : (lo_f & ~hi_f);
      gate_pfc <= !shut_all && cmd_f[NCMD-1];
      fault_n  <= !shut_all;
    end
  end

  // R4
  trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oc_hit |=> (!fault_n && gate_hi == '0 && gate_lo == '0 && !gate_pfc));

  // R7
  uvmain_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_main_s |=> (!fault_n && gate_hi == '0 && gate_lo == '0 && !gate_pfc));

  for (genvar p = 0; p < PHASES; p++) begin : g_chk
    // R3
    leg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_f[p] && lo_f[p]) |=> (!gate_hi[p] && !gate_lo[p]));

    // R8
    boot_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uv_boot_s[p] |=> !gate_hi[p]);
  end
endmodule

// File: tb/gate_interlock_bench.sv
`timescale 1ns/1ps
module gate_interlock_bench;
  localparam int unsigned BLK = 8;
  localparam int unsigned CLR = 40;
  localparam int unsigned MPW = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hi_cmd = '0;
  logic [2:0] lo_cmd = '0;
  logic       pfc_cmd = 1'b0;
  logic       oc_inv = 1'b0;
  logic       oc_pfc = 1'b0;
  logic       uv_main = 1'b1;
  logic [2:0] uv_boot = '0;
  logic [2:0] gate_hi;
  logic [2:0] gate_lo;
  logic       gate_pfc;
  logic       fault_n;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gate_interlock #(.BLANK_CYC(BLK), .CLEAR_CYC(CLR), .MIN_PULSE_CYC(MPW)) u_gate_interlock (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd), .pfc_cmd(pfc_cmd),
    .oc_inv(oc_inv), .oc_pfc(oc_pfc), .uv_main(uv_main), .uv_boot(uv_boot),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .gate_pfc(gate_pfc), .fault_n(fault_n));

  // fields: req(4) hi(3) lo(3) pfc(1) boot(3) | exp_hi(3) exp_lo(3) exp_pfc(1) exp_fault_n(1)
  localparam int NV = 8;
  localparam logic [21:0] VECS [0:NV-1] = '{
    {4'd2, 3'b001, 3'b000, 1'b0, 3'b000, 3'b001, 3'b000, 1'b0, 1'b1}, // R2 upper only
    {4'd2, 3'b000, 3'b110, 1'b1, 3'b000, 3'b000, 3'b110, 1'b1, 1'b1}, // R2 lower plus pfc
    {4'd2, 3'b101, 3'b010, 1'b0, 3'b000, 3'b101, 3'b010, 1'b0, 1'b1}, // R2 mixed
    {4'd3, 3'b111, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000, 1'b1, 1'b1}, // R3 all legs both
    {4'd3, 3'b011, 3'b110, 1'b0, 3'b000, 3'b001, 3'b100, 1'b0, 1'b1}, // R3 middle leg both
    {4'd8, 3'b111, 3'b000, 1'b0, 3'b010, 3'b101, 3'b000, 1'b0, 1'b1}, // R8 one boot low
    {4'd8, 3'b100, 3'b011, 1'b1, 3'b111, 3'b000, 3'b011, 1'b1, 1'b1}, // R8 all boot low
    {4'd2, 3'b000, 3'b000, 1'b0, 3'b000, 3'b000, 3'b000, 1'b0, 1'b1}  // R2 idle
  };

  function automatic logic [7:0] outs();
    return {gate_hi, gate_lo, gate_pfc, fault_n};
  endfunction

  task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", rq, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #999000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit moved;
    bit seen;
    step(3);
    chk("R1 in reset", outs(), 8'b000_000_0_0);
    rst_n = 1'b1;
    hi_cmd = 3'b001;
    step(20);
    chk("R1 held by uv_main", outs(), 8'b000_000_0_0);
    uv_main = 1'b0;
    step(20);
    chk("R1 released", outs(), 8'b001_000_0_1);

    for (int v = 0; v < NV; v++) begin
      {hi_cmd, lo_cmd, pfc_cmd, uv_boot} = VECS[v][17:8];
      step(15);
      chk($sformatf("R%0d vector %0d", VECS[v][21:18], v), outs(), VECS[v][7:0]);
    end

    // R9 short off pulse on an active command
    hi_cmd = 3'b001;
    step(15);
    moved = 1'b0;
    hi_cmd = 3'b000;
    step(MPW - 2);
    hi_cmd = 3'b001;
    for (int k = 0; k < 15; k++) begin
      step(1);
      if (gate_hi != 3'b001) moved = 1'b1;
    end
    chk("R9 short off pulse", {7'b0, moved}, 8'd0);

    // R9 short on pulse
    hi_cmd = 3'b000;
    step(15);
    moved = 1'b0;
    hi_cmd = 3'b010;
    step(MPW - 2);
    hi_cmd = 3'b000;
    for (int k = 0; k < 15; k++) begin
      step(1);
      if (gate_hi != 3'b000) moved = 1'b1;
    end
    chk("R9 short on pulse", {7'b0, moved}, 8'd0);

    // R9 pulse of exactly the filter width passes
    seen = 1'b0;
    hi_cmd = 3'b010;
    step(MPW);
    hi_cmd = 3'b000;
    for (int k = 0; k < 15; k++) begin
      step(1);
      if (gate_hi == 3'b010) seen = 1'b1;
    end
    chk("R9 full width pulse", {7'b0, seen}, 8'd1);

    // R4 short over-current glitch is blanked
    hi_cmd = 3'b001;
    pfc_cmd = 1'b1;
    step(15);
    moved = 1'b0;
    oc_inv = 1'b1;
    step(BLK - 4);
    oc_inv = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step(1);
      if (!fault_n || gate_hi != 3'b001 || !gate_pfc) moved = 1'b1;
    end
    chk("R4 glitch ignored", {7'b0, moved}, 8'd0);

    // R4 sustained PFC over-current trips everything
    oc_pfc = 1'b1;
    step(30);
    chk("R4 trip", outs(), 8'b000_000_0_0);

    // R5 clearance wait
    oc_pfc = 1'b0;
    step(30);
    chk("R5 still waiting", outs(), 8'b000_000_0_0);
    step(25);
    chk("R5 recovered", outs(), 8'b001_000_1_1);

    // R6 glitch inside the wait restarts it
    oc_inv = 1'b1;
    step(30);
    oc_inv = 1'b0;
    step(20);
    oc_inv = 1'b1;
    step(3);
    oc_inv = 1'b0;
    step(30);
    chk("R6 wait restarted", outs(), 8'b000_000_0_0);
    step(30);
    chk("R6 recovered", outs(), 8'b001_000_1_1);

    // R7 main undervoltage
    uv_main = 1'b1;
    step(10);
    chk("R7 shutdown", outs(), 8'b000_000_0_0);
    uv_main = 1'b0;
    step(5);
    chk("R7 immediate resume", outs(), 8'b001_000_1_1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule